// File: doc/BRIEF.md
# Minimal PCI Memory Target Bridge

This block is a stripped-down PCI target that lets one bus-mastering network controller reach a 32-bit local memory. It watches the shared bus for the start of a transaction. It claims the transaction only when the command is a memory read or memory write and the address falls inside a single fixed window. It then turns every data phase into exactly one word access on a simple synchronous memory port, which has a request and ready handshake.

No data is read ahead of the master. The cache-oriented read commands behave exactly like a plain read, and the write-and-invalidate command behaves like a plain write. Parity is neither produced nor checked. The processor side owns the memory through a grant input, and the target touches memory only while that grant is high. If the grant is withheld too long during the first data phase, the target asks the master to retry.

Top module: `pciMemTarget`

## Requirements
- R1: After reset, devselN, trdyN and stopN are high, tgtOe, adOe and memReq are low.
- R2: A command 0110 (read) or 0111 (write) whose address lies in the window is claimed with medium timing. devselN is still high in the clock after the address phase and low in the clock after that.
- R3: An address outside the window, or any other command such as 0010/0011 (I/O read and write), is never claimed. devselN stays high and memReq never rises.
- R4: Commands 1100 and 1110 behave exactly like 0110, and command 1111 behaves exactly like 0111.
- R5: A read data phase issues exactly one memory access, for the word currently addressed, and puts that word on adOut while trdyN is low. No access is made beyond the final phase. adOe is high only while read data is presented.
- R6: A write data phase writes adIn to memory with memBe equal to the inverse of cbeN, so only the enabled bytes change.
- R7: trdyN stays high until memory signals ready and falls in the next clock. With a memory latency of L extra clocks, the first phase shows L+2 clocks of devselN low with trdyN high.
- R8: Within a burst, each completed phase advances the word address by one (byte address by 4).
- R9: memReq is never high while memGrant is low.
- R10: If memGrant stays low for 16 clocks of the first data phase, stopN goes low with trdyN high (retry), and no memory access is made.
- R11: After the final phase completes, or after a retry ends, devselN, trdyN and stopN are high in the next clock, and tgtOe is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| adIn | input | 32 | Address/data from the bus |
| adOut | output | 32 | Read data toward the bus |
| adOe | output | 1 | Drive enable for adOut |
| cbeN | input | 4 | Command / active-low byte enables |
| frameN | input | 1 | Transaction framing, active low |
| irdyN | input | 1 | Initiator ready, active low |
| devselN | output | 1 | Device select, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Stop request, active low |
| tgtOe | output | 1 | Drive enable for devselN, trdyN, stopN |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | WIN_BITS-2 | Memory word address |
| memBe | output | 4 | Memory byte enables |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| memReady | input | 1 | Memory access done |
| memGrant | input | 1 | Processor grants memory to the target |

## Verification
A wrong state in the controller shows at devselN within one or two clocks of the address phase: a missed claim, a claim that comes too early, or a claim on a foreign command is visible at once. A stale or wrongly stepped burst address shows up as wrong words on adOut, or as wrong contents read back, in the very phase that follows. An extra memory access shows as a surplus request that the memory model counts. A miscounted retry timer moves the stopN pulse away from the sixteenth waiting clock.

// File: rtl/pciTgtPkg.sv
package pciTgtPkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_DATA,
    ST_XFER,
    ST_RETRY,
    ST_TURN
  } tgtState_t;

  typedef struct packed {
    logic latchAddr;
    logic advance;
    logic captureRd;
  } pathCtl_t;

  localparam logic [3:0] CMD_MRD = 4'b0110;
  localparam logic [3:0] CMD_MWR = 4'b0111;
  localparam logic [3:0] CMD_MRM = 4'b1100;
  localparam logic [3:0] CMD_MRL = 4'b1110;
  localparam logic [3:0] CMD_MWI = 4'b1111;
endpackage

// File: rtl/pciTgtPath.sv
module pciTgtPath
  import pciTgtPkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int WIN_BITS = 16,
  localparam int MEM_AW = WIN_BITS - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [31:0]       adIn,
  input  logic [3:0]        cbeN,
  input  logic [DATA_W-1:0] memRdata,
  output logic              winHit,
  output logic              cmdRead,
  output logic              cmdWrite,
  output logic [MEM_AW-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdHold
);
  logic [31:0] addrReg;

  // window compare on the upper address bits only
  assign winHit = (adIn[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);

  always_comb begin
    cmdRead  = 1'b0;
    cmdWrite = 1'b0;
    unique case (cbeN)
      CMD_MRD, CMD_MRM, CMD_MRL: cmdRead  = 1'b1;
      CMD_MWR, CMD_MWI:          cmdWrite = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctl.latchAddr) begin
      addrReg <= {adIn[31:2], 2'b00};
    end else if (ctl.advance) begin
      addrReg <= addrReg + 32'd4;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHold <= '0;
    end else if (ctl.captureRd) begin
      rdHold <= memRdata;
    end
  end

  assign memAddr  = addrReg[WIN_BITS-1:2];
  assign memBe    = ~cbeN;
  assign memWdata = adIn;

  // the word address moves only when the control asks for it
  assert_addr_moves_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> ($past(ctl.advance) || $past(ctl.latchAddr)));
endmodule

// File: rtl/pciTgtCtrl.sv
module pciTgtCtrl
  import pciTgtPkg::*;
#(
  parameter int RETRY_LIMIT = 16,
  localparam int CNT_W = $clog2(RETRY_LIMIT + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameN,
  input  logic     irdyN,
  input  logic     winHit,
  input  logic     cmdRead,
  input  logic     cmdWrite,
  input  logic     memGrant,
  input  logic     memReady,
  output pathCtl_t ctl,
  output logic     devselN,
  output logic     trdyN,
  output logic     stopN,
  output logic     tgtOe,
  output logic     adOe,
  output logic     memReq,
  output logic     memWe
);
  tgtState_t state, nextState;
  logic frameNq;
  logic isRead, claimReg, firstPhase;
  logic [CNT_W-1:0] waitCnt;
  logic addrPhase, claimNow, phaseGo;

  assign addrPhase = (state == ST_IDLE) && !frameN && frameNq;
  assign claimNow  = winHit && (cmdRead || cmdWrite);
  // a write needs the initiator's data, a read can fetch at once
  assign phaseGo   = (state == ST_DATA) && memGrant && (isRead || !irdyN);

  assign memReq = phaseGo;
  assign memWe  = phaseGo && !isRead;

  always_comb begin
    nextState     = state;
    ctl           = '0;
    ctl.latchAddr = addrPhase;
    unique case (state)
      ST_IDLE:   if (addrPhase) nextState = ST_DECODE;
      ST_DECODE: nextState = claimReg ? ST_DATA : ST_IDLE;
      ST_DATA: begin
        if (phaseGo && memReady) begin
          ctl.captureRd = isRead;
          nextState     = ST_XFER;
        end else if (firstPhase && !memGrant &&
                     waitCnt == CNT_W'(RETRY_LIMIT - 1)) begin
          nextState = ST_RETRY;
        end
      end
      ST_XFER: begin
        if (!irdyN) begin
          ctl.advance = 1'b1;
          nextState   = frameN ? ST_TURN : ST_DATA;
        end
      end
      ST_RETRY:  if (frameN) nextState = ST_TURN;
      ST_TURN:   nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      frameNq    <= 1'b1;
      isRead     <= 1'b0;
      claimReg   <= 1'b0;
      firstPhase <= 1'b0;
      waitCnt    <= '0;
    end else begin
      state   <= nextState;
      frameNq <= frameN;
      if (addrPhase) begin
        isRead   <= cmdRead;
        claimReg <= claimNow;
      end
      if (state == ST_DECODE) begin
        firstPhase <= 1'b1;
        waitCnt    <= '0;
      end else if (ctl.advance) begin
        firstPhase <= 1'b0;
      end else if (state == ST_DATA && firstPhase && !memGrant) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign devselN = !(state == ST_DATA || state == ST_XFER || state == ST_RETRY);
  assign trdyN   = (state != ST_XFER);
  assign stopN   = (state != ST_RETRY);
  assign tgtOe   = (state != ST_IDLE) && (state != ST_DECODE);
  assign adOe    = (state == ST_XFER) && isRead;

  assert_claim_medium_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase && claimNow) |=> devselN ##1 !devselN);
  assert_no_foreign_claim_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase && !claimNow) |=> ##1 devselN);
  assert_rd_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (!trdyN && !devselN));
  assert_trdy_after_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trdyN) |-> $past(memReady));
  assert_retry_no_trdy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> (trdyN && !memReq));
  assert_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !irdyN && frameN) |=> (devselN && trdyN && stopN));
endmodule

// File: rtl/pciMemTarget.sv
module pciMemTarget
  import pciTgtPkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int WIN_BITS = 16,
  parameter int RETRY_LIMIT = 16,
  localparam int MEM_AW = WIN_BITS - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       adIn,
  output logic [31:0]       adOut,
  output logic              adOe,
  input  logic [3:0]        cbeN,
  input  logic              frameN,
  input  logic              irdyN,
  output logic              devselN,
  output logic              trdyN,
  output logic              stopN,
  output logic              tgtOe,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady,
  input  logic              memGrant
);
  pathCtl_t ctl;
  logic winHit, cmdRead, cmdWrite;

  pciTgtCtrl #(.RETRY_LIMIT(RETRY_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .winHit(winHit), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .memGrant(memGrant), .memReady(memReady), .ctl(ctl),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .tgtOe(tgtOe),
    .adOe(adOe), .memReq(memReq), .memWe(memWe)
  );

  pciTgtPath #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) i_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .adIn(adIn), .cbeN(cbeN),
    .memRdata(memRdata), .winHit(winHit), .cmdRead(cmdRead),
    .cmdWrite(cmdWrite), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .rdHold(adOut)
  );
endmodule

// File: tb/test_pciMemTarget.sv
module test_pciMemTarget;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] adIn = '0;
  logic [31:0] adOut;
  logic adOe;
  logic [3:0] cbeN = 4'hF;
  logic frameN = 1'b1;
  logic irdyN = 1'b1;
  logic devselN, trdyN, stopN, tgtOe, memReq, memWe;
  logic [13:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic memReady = 1'b0;
  logic memGrant = 1'b1;

  int errors = 0;
  int checks = 0;
  int lat = 0;
  int latCnt = 0;
  int accCnt = 0;
  int noGrantReq = 0;
  logic [31:0] mem [0:63];
  logic [13:0] accAddr [0:15];
  logic [31:0] wBuf [0:7];
  logic [31:0] rBuf [0:7];

  always #(CLK_P/2) clk = ~clk;

  pciMemTarget i_pciMemTarget (
    .clk(clk), .rstN(rstN), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .cbeN(cbeN), .frameN(frameN), .irdyN(irdyN), .devselN(devselN),
    .trdyN(trdyN), .stopN(stopN), .tgtOe(tgtOe), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .memGrant(memGrant)
  );

  // memory model with programmable latency
  always @(posedge clk) begin
    if (memReq && !memReady) begin
      if (latCnt >= lat) begin
        memReady <= 1'b1;
        memRdata <= mem[memAddr[5:0]];
        if (memWe) begin
          for (int b = 0; b < 4; b++)
            if (memBe[b]) mem[memAddr[5:0]][b*8 +: 8] <= memWdata[b*8 +: 8];
        end
        if (accCnt < 16) accAddr[accCnt] <= memAddr;
        accCnt <= accCnt + 1;
        latCnt <= 0;
      end else begin
        latCnt <= latCnt + 1;
      end
    end else begin
      memReady <= 1'b0;
    end
  end

  always @(negedge clk) if (memReq && !memGrant) noGrantReq++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runTxn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                        input logic [3:0] be, output int waitFirst, output bit claimed,
                        output bit stopped);
    int i = 0;
    int cyc = 0;
    bit adv = 0;
    bit isWr = (cmd == 4'b0111) || (cmd == 4'b1111);
    waitFirst = 0; claimed = 0; stopped = 0;
    @(negedge clk); frameN = 1'b0; adIn = addr; cbeN = cmd; irdyN = 1'b1;
    @(negedge clk);
    check(devselN === 1'b1, "R2 devsel high right after address phase", {31'd0, devselN}, 32'd1);
    cbeN = ~be; irdyN = 1'b0; frameN = (n == 1); adIn = isWr ? wBuf[0] : 32'd0;
    forever begin
      @(negedge clk); cyc++;
      if (adv) begin adv = 0; adIn = isWr ? wBuf[i] : 32'd0; frameN = (i == n - 1); end
      if (!devselN) claimed = 1;
      if (!stopN) begin stopped = 1; break; end
      if (!trdyN) begin
        if (!isWr) rBuf[i] = adOut;
        i++;
        if (i == n) break;
        adv = 1;
      end else if (!devselN && i == 0) waitFirst++;
      if (!claimed && cyc >= 6) break;
      if (cyc > 300) begin check(0, "R7 transaction hung", 32'd0, 32'd1); break; end
    end
    @(negedge clk);
    if (claimed)
      check(devselN && trdyN && stopN, "R11 release after end", {29'd0, devselN, trdyN, stopN}, 32'd7);
    frameN = 1'b1; irdyN = 1'b1; cbeN = 4'hF; adIn = '0;
    @(negedge clk);
    check(tgtOe === 1'b0, "R11 drivers off", {31'd0, tgtOe}, 32'd0);
  endtask

  task automatic testReset();
    check(devselN && trdyN && stopN, "R1 reset handshake high", {29'd0, devselN, trdyN, stopN}, 32'd7);
    check(!tgtOe && !adOe && !memReq, "R1 reset enables low", {29'd0, tgtOe, adOe, memReq}, 32'd0);
  endtask

  task automatic testSingleRead();
    int w; bit c, s;
    lat = 0; accCnt = 0;
    runTxn(4'b0110, BASE + 32'h14, 1, 4'hF, w, c, s);
    check(c, "R2 read claimed", {31'd0, c}, 32'd1);
    check(rBuf[0] == mem[5], "R5 single read data", rBuf[0], mem[5]);
    check(accCnt == 1, "R5 one access, no prefetch", accCnt, 32'd1);
    check(w == 2, "R7 zero-latency wait count", w, 32'd2);
  endtask

  task automatic testBurstWrite();
    int w; bit c, s;
    lat = 2; accCnt = 0;
    for (int k = 0; k < 4; k++) wBuf[k] = 32'hC0DE_0000 + k;
    runTxn(4'b0111, BASE + 32'h20, 4, 4'hF, w, c, s);
    check(w == 4, "R7 wait states follow memory latency", w, 32'd4);
    check(accCnt == 4, "R6 one write per phase", accCnt, 32'd4);
    for (int k = 0; k < 4; k++) begin
      check(mem[8 + k] == 32'hC0DE_0000 + k, "R6 burst write data", mem[8 + k], 32'hC0DE_0000 + k);
      check(accAddr[k] == 14'(8 + k), "R8 write address steps", {18'd0, accAddr[k]}, 8 + k);
    end
    lat = 0;
  endtask

  task automatic testBurstReadMultiple();
    int w; bit c, s;
    lat = 1; accCnt = 0;
    runTxn(4'b1100, BASE + 32'h40, 4, 4'hF, w, c, s);
    check(c, "R4 read-multiple claimed", {31'd0, c}, 32'd1);
    for (int k = 0; k < 4; k++)
      check(rBuf[k] == mem[16 + k], "R8 burst read words in order", rBuf[k], mem[16 + k]);
    check(accCnt == 4, "R5 no access beyond last phase", accCnt, 32'd4);
    lat = 0;
  endtask

  task automatic testAliases();
    int w; bit c, s;
    accCnt = 0;
    runTxn(4'b1110, BASE + 32'h30, 2, 4'hF, w, c, s);
    check(rBuf[0] == mem[12] && rBuf[1] == mem[13], "R4 read-line acts as read", rBuf[1], mem[13]);
    check(accCnt == 2, "R4 read-line no prefetch", accCnt, 32'd2);
    wBuf[0] = 32'h5A5A_A5A5;
    runTxn(4'b1111, BASE + 32'h0C, 1, 4'hF, w, c, s);
    check(mem[3] == 32'h5A5A_A5A5, "R4 write-invalidate acts as write", mem[3], 32'h5A5A_A5A5);
  endtask

  task automatic testByteEnables();
    int w; bit c, s;
    mem[40] = 32'h1122_3344;
    wBuf[0] = 32'hAABB_CCDD;
    runTxn(4'b0111, BASE + 32'hA0, 1, 4'b0101, w, c, s);
    runTxn(4'b0110, BASE + 32'hA0, 1, 4'hF, w, c, s);
    check(rBuf[0] == 32'h11BB_33DD, "R6 byte enables merge", rBuf[0], 32'h11BB_33DD);
  endtask

  task automatic testMiss();
    int w; bit c, s;
    accCnt = 0;
    runTxn(4'b0110, 32'h4000_0010, 1, 4'hF, w, c, s);
    check(!c, "R3 outside window not claimed", {31'd0, c}, 32'd0);
    runTxn(4'b0010, BASE + 32'h10, 1, 4'hF, w, c, s);
    check(!c, "R3 I/O read not claimed", {31'd0, c}, 32'd0);
    runTxn(4'b0011, BASE + 32'h10, 1, 4'hF, w, c, s);
    check(!c, "R3 I/O write not claimed", {31'd0, c}, 32'd0);
    check(accCnt == 0, "R3 no memory access on miss", accCnt, 32'd0);
  endtask

  task automatic testRetry();
    int w; bit c, s;
    accCnt = 0; memGrant = 1'b0;
    runTxn(4'b0110, BASE + 32'h04, 1, 4'hF, w, c, s);
    check(s, "R10 retry signalled", {31'd0, s}, 32'd1);
    check(w == 16, "R10 retry after 16 waiting clocks", w, 32'd16);
    check(accCnt == 0, "R10 no access on retry", accCnt, 32'd0);
    memGrant = 1'b1;
  endtask

  task automatic testLateGrant();
    int w; bit c, s;
    accCnt = 0; memGrant = 1'b0;
    fork begin repeat (6) @(negedge clk); memGrant = 1'b1; end join_none
    runTxn(4'b0110, BASE + 32'h08, 1, 4'hF, w, c, s);
    check(!s && rBuf[0] == mem[2], "R9 late grant still completes", rBuf[0], mem[2]);
    check(noGrantReq == 0, "R9 no request without grant", noGrantReq, 32'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'hA500_0000 + k * 32'h0101;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testSingleRead();
    testBurstWrite();
    testBurstReadMultiple();
    testAliases();
    testByteEnables();
    testMiss();
    testRetry();
    testLateGrant();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule